// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register Block

This block gathers 32 level-sensitive interrupt requests and raises one interrupt line toward a processor. Software reaches it through a simple synchronous register bus. For each source it can see the live request level or a latched rising-edge record. Software picks between the two for each bit. A set/clear mask gates the sources, and each source carries a 3-bit urgency value. A threshold register lets only sources more urgent than the level now being served raise the line.

A handler first reads the acknowledge register. That read returns the winning source number and, in the same cycle, raises the threshold to the winner's urgency. It also keeps the old threshold in a saved-threshold register. The handler then reads the saved-threshold register, which drops the interrupt line if nothing else qualifies. After the source is serviced, the handler writes the threshold back. Once the line has been raised, it stays up until such a read is made while no source qualifies, even if the source that caused it is masked in the meantime.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The raw status bit for source n equals the level of `irq_src[n]` one clock earlier, whether or not the source is enabled.
- R2: A sticky bit sets when its source goes from 0 to 1. Writing 1 to that bit position of the status register (offset 0x04) clears it. Each bit of the select register (offset 0x204) picks raw (0) or sticky (1) for that status bit, and reading 0x204 returns the select register.
- R3: A write to offset 0x08 ORs the data into the enable mask. A write to offset 0x0C clears the bits that are 1 in the data. Reading either offset returns the mask.
- R4: The masked status (offset 0x00) is the selected status ANDed with the enable mask. A source with a masked status bit of 1 is active.
- R5: The current number (offset 0x20) is the active source with the lowest urgency value. Ties go to the lowest source index. When no source is active, it reads 0.
- R6: The trigger flag, seen on `irq_out`, sets on the next clock edge once an active source has an urgency value strictly below the threshold (offset 0x2C, 4 bits). A threshold of 8 lets every urgency through.
- R7: A read of offset 0x24 returns the current number. In the same cycle it copies the threshold into the saved-threshold register and loads the current source's urgency into the threshold.
- R8: The trigger flag stays set while no source qualifies, even after its source is masked. It clears only on a read of offset 0x28 made while no source qualifies. That read returns the saved threshold.
- R9: The urgency of source n is read and written at offset 0x300 + 4*n, in bits [2:0].
- R10: After reset, the mask, sticky bits and select register are 0. The threshold and saved threshold are 8, every urgency is 7, and `irq_out` is 0.
- R11: Read data appears on `bus_rdata` on the clock edge that samples `bus_re` and holds until the next read. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Level-sensitive interrupt requests |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Trigger flag toward the processor |

## Verification
The assertions assume that `bus_we` and `bus_re` are never high in the same cycle. They also assume that the request inputs are already synchronous to `clk`, since the sticky edge check compares the input with its registered copy. The stimulus drives every input on the falling edge and issues each access as a lone one-cycle strobe followed by an idle cycle. It changes requests only between accesses. This keeps the acknowledge side effect and threshold writes from ever landing on the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_MASKED  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CURNUM  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_SAVED   = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_THRESH  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_STKSEL  = 12'h204;
  localparam logic [4:0]        PRIO_PAGE   = 5'b00110;  // 0x300..0x37F
endpackage

// File: rtl/irqc_src_status.sv
module irqc_src_status #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_src,
  input  logic [NSRC-1:0] stk_sel,
  input  logic [NSRC-1:0] stk_clr,
  input  logic [NSRC-1:0] en_set,
  input  logic [NSRC-1:0] en_clr,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] sel_sts,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] active
);
  logic [NSRC-1:0] sticky_q;
  logic [NSRC-1:0] rise;

  assign rise = irq_src & ~raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      raw_q    <= irq_src;
      sticky_q <= (sticky_q & ~stk_clr) | rise;
      mask_q   <= (mask_q | en_set) & ~en_clr;
    end
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_sel
      assign sel_sts[g] = stk_sel[g] ? sticky_q[g] : raw_q[g];
    end
  endgenerate

  assign active = sel_sts & mask_q;

  AST_STICKY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sticky_q & $past(rise)) == $past(rise))); // R2

  AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (raw_q == $past(irq_src))); // R1

  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|en_set && !(|(en_set & en_clr))) |=> ((mask_q & $past(en_set)) == $past(en_set))); // R3
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          active,
  input  logic [NSRC-1:0][PW-1:0]  prio,
  output logic                     any_act,
  output logic [IDXW-1:0]          win_num,
  output logic [PW-1:0]            win_prio
);
  always_comb begin
    any_act  = 1'b0;
    win_num  = '0;
    win_prio = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!any_act || prio[i] < win_prio)) begin
        any_act  = 1'b1;
        win_num  = IDXW'(i);
        win_prio = prio[i];
      end
    end
  end

  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    any_act |-> active[win_num]); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !any_act |-> (win_num == '0)); // R5
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger (
  input  logic clk,
  input  logic rst,
  input  logic qualify,
  input  logic clr_req,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (qualify) irq_q <= 1'b1;
    else if (clr_req) irq_q <= 1'b0;
  end

  AST_TRIG_SETS: assert property (@(posedge clk) disable iff (rst)
    qualify |=> irq_q); // R6
  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_req) |=> irq_q); // R8
  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !qualify) |=> !irq_q); // R8
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IDXW = $clog2(NSRC),
  localparam int TW   = PW + 1,
  localparam logic [TW-1:0] T_OPEN = TW'(1 << PW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [NSRC-1:0]         stk_sel_q;
  logic [NSRC-1:0][PW-1:0] prio_q;
  logic [TW-1:0]           thresh_q;
  logic [TW-1:0]           saved_q;

  logic [NSRC-1:0] raw_q, sel_sts, mask_q, active;
  logic [NSRC-1:0] stk_clr, en_set, en_clr;
  logic            any_act, qualify;
  logic [IDXW-1:0] win_num;
  logic [PW-1:0]   win_prio;

  logic wr_status, wr_en_set, wr_en_clr, wr_thresh, wr_stksel, wr_prio;
  logic rd_ack, rd_saved, in_prio_page;
  logic [IDXW-1:0] prio_idx;

  assign in_prio_page = (bus_addr[ADDR_W-1:7] == PRIO_PAGE);
  assign prio_idx     = bus_addr[2 +: IDXW];

  assign wr_status = bus_we && (bus_addr == OFS_STATUS);
  assign wr_en_set = bus_we && (bus_addr == OFS_EN_SET);
  assign wr_en_clr = bus_we && (bus_addr == OFS_EN_CLR);
  assign wr_thresh = bus_we && (bus_addr == OFS_THRESH);
  assign wr_stksel = bus_we && (bus_addr == OFS_STKSEL);
  assign wr_prio   = bus_we && in_prio_page;
  assign rd_ack    = bus_re && (bus_addr == OFS_ACK);
  assign rd_saved  = bus_re && (bus_addr == OFS_SAVED);

  assign stk_clr = wr_status ? bus_wdata[NSRC-1:0] : '0;
  assign en_set  = wr_en_set ? bus_wdata[NSRC-1:0] : '0;
  assign en_clr  = wr_en_clr ? bus_wdata[NSRC-1:0] : '0;

  irqc_src_status #(.NSRC(NSRC)) u_status (
    .clk     (clk),
    .rst     (rst),
    .irq_src (irq_src),
    .stk_sel (stk_sel_q),
    .stk_clr (stk_clr),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .raw_q   (raw_q),
    .sel_sts (sel_sts),
    .mask_q  (mask_q),
    .active  (active)
  );

  irqc_resolver #(.NSRC(NSRC), .PW(PW)) u_resolver (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .prio     (prio_q),
    .any_act  (any_act),
    .win_num  (win_num),
    .win_prio (win_prio)
  );

  assign qualify = any_act && ({1'b0, win_prio} < thresh_q);

  irqc_trigger u_trigger (
    .clk     (clk),
    .rst     (rst),
    .qualify (qualify),
    .clr_req (rd_saved),
    .irq_q   (irq_out)
  );

  // Control registers; the acknowledge side effect wins over a threshold write.
  always_ff @(posedge clk) begin
    if (rst) begin
      stk_sel_q <= '0;
      thresh_q  <= T_OPEN;
      saved_q   <= T_OPEN;
    end else begin
      if (wr_stksel) stk_sel_q <= bus_wdata[NSRC-1:0];
      if (rd_ack) begin
        saved_q  <= thresh_q;
        thresh_q <= {1'b0, prio_q[win_num]};
      end else if (wr_thresh) begin
        thresh_q <= bus_wdata[TW-1:0];
      end
    end
  end

  // Urgency table, one small entry per source.
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_prio
      always_ff @(posedge clk) begin
        if (rst)
          prio_q[g] <= '1;
        else if (wr_prio && (prio_idx == IDXW'(g)))
          prio_q[g] <= bus_wdata[PW-1:0];
      end
    end
  endgenerate

  // Registered read mux.
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (in_prio_page) begin
      rd_val = DATA_W'(prio_q[prio_idx]);
    end else begin
      case (bus_addr)
        OFS_MASKED: rd_val = DATA_W'(active);
        OFS_STATUS: rd_val = DATA_W'(sel_sts);
        OFS_EN_SET,
        OFS_EN_CLR: rd_val = DATA_W'(mask_q);
        OFS_CURNUM,
        OFS_ACK:    rd_val = DATA_W'(win_num);
        OFS_SAVED:  rd_val = DATA_W'(saved_q);
        OFS_THRESH: rd_val = DATA_W'(thresh_q);
        OFS_STKSEL: rd_val = DATA_W'(stk_sel_q);
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  AST_ACK_SAVES: assert property (@(posedge clk) disable iff (rst)
    rd_ack |=> (saved_q == $past(thresh_q))); // R7
  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && any_act) |=> (thresh_q == {1'b0, $past(win_prio)})); // R7
  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re)); // R11
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_src = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Monitor: pops expected read data after the capturing edge.
  always @(posedge clk) rd_pend <= bus_re;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: irq_out got %b expected %b", t, irq_out, e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R10 reset state
    chk_irq(1'b0, "R10 irq after reset");
    rd(12'h02C, 32'd8, "R10 threshold reset");
    rd(12'h008, 32'h0, "R10 mask reset");
    rd(12'h028, 32'd8, "R10 saved reset");
    rd(12'h31C, 32'd7, "R10 urgency reset");

    // R9 urgency table
    wr(12'h300 + 12'd4*3,  32'd5);
    wr(12'h300 + 12'd4*7,  32'd2);
    wr(12'h300 + 12'd4*9,  32'd2);
    wr(12'h300 + 12'd4*12, 32'd6);
    rd(12'h31C, 32'd2, "R9 urgency of source 7");
    rd(12'h330, 32'd6, "R9 urgency of source 12");

    // R1 raw status with source disabled
    @(negedge clk); irq_src[3] = 1'b1;
    idle(2);
    rd(12'h004, 32'h8, "R1 raw status disabled source");
    rd(12'h000, 32'h0, "R4 masked status empty");
    rd(12'h020, 32'h0, "R5 no active source");
    chk_irq(1'b0, "R6 disabled source no trigger");

    // R3 enable mask
    wr(12'h008, (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 9));
    rd(12'h00C, 32'h0000_0288, "R3 mask read at clear offset");
    rd(12'h000, 32'h8, "R4 masked status one source");
    rd(12'h020, 32'd3, "R5 single active source");
    chk_irq(1'b1, "R6 trigger with open threshold");

    // R5 tie goes to lowest index
    @(negedge clk); irq_src[7] = 1'b1; irq_src[9] = 1'b1;
    idle(2);
    rd(12'h020, 32'd7, "R5 tie lowest index");

    // R7 acknowledge
    rd(12'h024, 32'd7, "R7 acknowledge returns winner");
    rd(12'h02C, 32'd2, "R7 threshold raised to winner");
    chk_irq(1'b1, "R8 flag holds before clear read");
    rd(12'h028, 32'd8, "R8 saved threshold returned");
    chk_irq(1'b0, "R8 clear read with nothing qualifying");

    // R8 hold after masking
    wr(12'h02C, 32'd8);
    idle(1);
    chk_irq(1'b1, "R6 threshold 8 lets urgency through");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h008, 32'h0, "R3 clear write empties mask");
    idle(2);
    chk_irq(1'b1, "R8 flag held after masking");
    rd(12'h028, 32'd8, "R8 saved threshold on clear");
    chk_irq(1'b0, "R8 flag cleared");

    // R2 sticky status
    wr(12'h204, 32'h1 << 12);
    rd(12'h204, 32'h1 << 12, "R2 select readback");
    wr(12'h008, 32'h1 << 12);
    @(negedge clk); irq_src[12] = 1'b1;
    idle(2);
    @(negedge clk); irq_src[12] = 1'b0;
    idle(2);
    rd(12'h004, 32'h0000_1288, "R2 sticky held after source drop");
    rd(12'h000, 32'h0000_1000, "R4 masked sticky bit");
    chk_irq(1'b1, "R6 sticky source triggers");
    wr(12'h004, 32'h1 << 12);
    rd(12'h004, 32'h0000_0288, "R2 write one clears sticky");
    rd(12'h028, 32'd8, "R8 clear after sticky cleared");
    chk_irq(1'b0, "R8 flag cleared after sticky service");

    // R6 strict threshold compare
    wr(12'h02C, 32'd5);
    wr(12'h008, 32'h1 << 3);
    idle(2);
    chk_irq(1'b0, "R6 equal urgency blocked");
    wr(12'h02C, 32'd6);
    idle(1);
    chk_irq(1'b1, "R6 lower urgency passes");
    rd(12'h028, 32'd8, "R8 clear read while qualifying");
    chk_irq(1'b1, "R8 flag kept while source qualifies");

    // R11 unmapped offset
    rd(12'h100, 32'h0, "R11 unmapped reads zero");
    idle(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule